// File: doc/BRIEF.md
# Request/Wait Read Master

This block is the master side of a simple single-word read bus made of three wires: a request line driven by the master, a wait line driven by the servant, and a data bus driven by the servant. A local client asks for a read by pulsing a command input while the block is ready. The block then raises the request and counts clock cycles against a fixed access deadline. If the servant never raises wait during that window, the data bus is sampled on the deadline edge. If the servant does raise wait, the transfer becomes a handshake: the request stays high until wait drops, and the data is taken at that moment.

The wait line may come from another clock domain. It passes through a two-flop synchroniser, and the handshake completes on the falling edge of the synchronised copy. The data bus is sampled directly, because the protocol requires the servant to hold it stable whenever the master samples it. An optional timeout stops a handshake that never completes. It drops the request and reports an error instead of data. Every transfer ends with either a one-cycle done pulse, with the captured word on the read-data output, or a one-cycle error pulse. The block then keeps the request low for an idle phase before it accepts the next command.

Top module: `rwm_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, bus_req_o, done_o and err_o are low and cmd_ready_o is high.
- R2: A cmd_valid_i seen high at a clock edge while cmd_ready_o is high makes bus_req_o high from the next cycle. cmd_ready_o is low in every cycle in which bus_req_o is high.
- R3: If the master sees no wait on any of the first ACCESS_CYC clock edges that follow the rise of bus_req_o, it samples bus_data_i on the ACCESS_CYC-th of those edges. bus_req_o is then high for exactly ACCESS_CYC cycles, and done_o pulses in the next cycle with the sampled word on rdata_o.
- R4: If the master sees wait on any of those first ACCESS_CYC edges, including the last one, it captures nothing at the deadline and keeps bus_req_o high.
- R5: A level of bus_wait_i that is first sampled at clock edge k takes effect at the master's decision on edge k+2 (two-flop synchroniser). In a handshake, bus_data_i is captured and bus_req_o is dropped on the edge at which the master first sees wait low.
- R6: Each fall of bus_req_o comes with exactly one of done_o or err_o, high in the first cycle in which bus_req_o is low.
- R7: done_o and err_o are each high for a single cycle and are never high together.
- R8: After bus_req_o falls, it stays low for at least two cycles, and cmd_ready_o is high in the second of them.
- R9: With the timeout enabled, if the master still sees wait high on the TIMEOUT_CYC-th edge after entering the handshake, it drops bus_req_o, pulses err_o instead of done_o, and leaves rdata_o unchanged.
- R10: cmd_valid_i seen while cmd_ready_o is low is ignored. It starts no further transfer after the current one ends.
- R11: rdata_o changes only in a cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Client read command, taken when cmd_ready_o is high |
| cmd_ready_o | output | 1 | High when a new command can be accepted |
| done_o | output | 1 | One-cycle pulse: rdata_o holds a fresh word |
| err_o | output | 1 | One-cycle pulse: handshake timed out |
| rdata_o | output | DATA_W | Last captured word |
| bus_req_o | output | 1 | Request line to the servant |
| bus_wait_i | input | 1 | Wait line from the servant, possibly asynchronous |
| bus_data_i | input | DATA_W | Data bus from the servant |

## Verification
Two events can fall on the same edge: the access deadline expires, and the synchronised wait shows its first high. In that case wait must win, and the master must switch to the handshake instead of sampling. The bench provokes this by having the servant model raise wait exactly two edges before the deadline, and also one edge later, where the master must already have sampled. It judges each case by the length of the request pulse, by whether done or error followed, and by whether the captured word is the one the servant drove at release or the one left on the bus at the deadline. Randomly chosen fast, slow and timed-out transfers are checked against the same rules, which the bench computes itself.

// File: rtl/rwm_pkg.sv
`timescale 1ns/1ps
package rwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HSHAKE = 2'd2,
    ST_GAP    = 2'd3
  } rwm_state_e;

  // width able to hold the larger of two cycle counts
  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction

  // true on the edge that completes 'limit' counted edges
  function automatic logic last_tick(input int unsigned count, input int unsigned limit);
    return (count + 1) == limit;
  endfunction

endpackage

// File: rtl/rwm_sync.sv
`timescale 1ns/1ps
module rwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rwm_tick_counter.sv
`timescale 1ns/1ps
module rwm_tick_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rwm_capture.sv
`timescale 1ns/1ps
module rwm_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/rwm_master.sv
`timescale 1ns/1ps
module rwm_master #(
  parameter int DATA_W      = 8,
  parameter int ACCESS_CYC  = 4,
  parameter bit TIMEOUT_EN  = 1'b1,
  parameter int TIMEOUT_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  input  logic              bus_wait_i,
  input  logic [DATA_W-1:0] bus_data_i
);
  import rwm_pkg::*;

  localparam int CNT_W = cnt_width(ACCESS_CYC, TIMEOUT_CYC);

  rwm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       cnt_ext;
  logic              wait_s, wait_q;

  // named events, also observed by the checker
  logic start_xfer, wait_seen, deadline_hit, wait_fall, wait_release;
  logic timeout_hit, capture_en, cnt_clr, cnt_inc;

  rwm_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst_n(rst_n), .d(bus_wait_i), .q(wait_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_s;
  end

  assign cnt_ext      = {{(32-CNT_W){1'b0}}, cnt};
  assign wait_fall    = wait_q & ~wait_s;
  assign start_xfer   = (state_q == ST_IDLE) & cmd_valid_i;
  // wait takes priority over the deadline on the same edge
  assign wait_seen    = (state_q == ST_ACCESS) & wait_s;
  assign deadline_hit = (state_q == ST_ACCESS) & ~wait_s & last_tick(cnt_ext, ACCESS_CYC);
  assign wait_release = (state_q == ST_HSHAKE) & wait_fall;

  generate
    if (TIMEOUT_EN) begin : g_tmo
      assign timeout_hit = (state_q == ST_HSHAKE) & wait_s & last_tick(cnt_ext, TIMEOUT_CYC);
    end else begin : g_no_tmo
      assign timeout_hit = 1'b0;
    end
  endgenerate

  assign capture_en = deadline_hit | wait_release;
  assign cnt_clr    = start_xfer | wait_seen;
  assign cnt_inc    = ((state_q == ST_ACCESS) & ~wait_s) | ((state_q == ST_HSHAKE) & wait_s);

  rwm_tick_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_xfer) state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (wait_seen)         state_d = ST_HSHAKE;
        else if (deadline_hit) state_d = ST_GAP;
      end
      ST_HSHAKE: if (wait_release | timeout_hit) state_d = ST_GAP;
      ST_GAP:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= capture_en;
      err_o   <= timeout_hit;
    end
  end

  // data bus sampled directly: the servant holds it stable at the sampling edge
  rwm_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(capture_en), .d(bus_data_i), .q(rdata_o)
  );

  assign bus_req_o   = (state_q == ST_ACCESS) | (state_q == ST_HSHAKE);
  assign cmd_ready_o = (state_q == ST_IDLE);
endmodule

// File: rtl/rwm_master_chk.sv
`timescale 1ns/1ps
module rwm_master_chk #(
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              bus_req_o,
  input logic              wait_s,
  input logic              wait_seen
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_len <= '0;
    else if (!bus_req_o)                hi_len <= '0;
    else if (hi_len != 16'hFFFF)        hi_len <= hi_len + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!bus_req_o && cmd_ready_o && !done_o && !err_o));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> bus_req_o);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> !cmd_ready_o);

  p_deadline_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |-> (hi_len >= 16'(ACCESS_CYC)));

  p_hold_on_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_seen |=> bus_req_o);

  p_drop_reason_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |-> (done_o ^ err_o));

  p_done_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_req_o && $past(bus_req_o)));

  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_idle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |=> !bus_req_o);

  p_timeout_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(wait_s));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o));
endmodule

bind rwm_master rwm_master_chk #(.DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o), .bus_req_o(bus_req_o),
  .wait_s(wait_s), .wait_seen(wait_seen)
);

// File: tb/sim_rwm_master.sv
`timescale 1ns/1ps
module sim_rwm_master;
  localparam int DW = 8;
  localparam int A  = 4;
  localparam int T  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          wait_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          cmd_ready, done, err, req;
  logic [DW-1:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  rwm_master #(.DATA_W(DW), .ACCESS_CYC(A), .TIMEOUT_EN(1'b1), .TIMEOUT_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .done_o(done), .err_o(err), .rdata_o(rdata), .bus_req_o(req),
    .bus_wait_i(wait_i), .bus_data_i(data_i)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // mode 0: fast, 1: wait then release, 2: wait never released
  function automatic bit goes_slow(input int w);
    return (w + 2) <= A;  // wait sampled at edge w is acted on at edge w+2
  endfunction

  function automatic int exp_len(input int mode, input int w, input int m);
    if (mode == 0) return A;
    if (!goes_slow(w)) return A;
    if (mode == 1) return m + 2;
    return w + 2 + T;
  endfunction

  function automatic logic [DW-1:0] exp_word(input int mode, input int w, input int m,
                                             input logic [DW-1:0] v, input logic [DW-1:0] j);
    if (mode == 0) return v;
    if (goes_slow(w)) return v;
    return (m <= A) ? v : j;   // wait too late: whatever is on the bus at the deadline
  endfunction

  task automatic xfer(input int mode, input int dly, input int w, input int m,
                      input int hold, input logic [DW-1:0] v);
    int len;
    bit seen_done, seen_err;
    logic [DW-1:0] junk, prev;
    bit exp_err;
    len = 0; seen_done = 0; seen_err = 0;
    junk = v ^ 8'hA5;
    prev = rdata;
    exp_err = (mode == 2) && goes_slow(w);
    @(negedge clk);
    check(cmd_ready === 1'b1, "R8 ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    data_i = junk;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      if (req) begin
        len++;
        if (len >= hold) cmd_valid = 1'b0;
        if (len == 1) check(cmd_ready === 1'b0, "R2 busy not ready", int'(cmd_ready), 0);
        if (mode == 0 && len == dly) data_i = v;
        if (mode != 0 && len == w) wait_i = 1'b1;
        if (mode == 1 && len == m) begin wait_i = 1'b0; data_i = v; end
      end else begin
        seen_done = done;
        seen_err = err;
        break;
      end
    end
    cmd_valid = 1'b0;
    wait_i = 1'b0;
    check(len == exp_len(mode, w, m),
          (mode == 0) ? "R3 req length fast" : (mode == 1) ? "R5 req length handshake" : "R9 req length timeout",
          len, exp_len(mode, w, m));
    check(seen_done == !exp_err, "R6 done at req fall", int'(seen_done), int'(!exp_err));
    check(seen_err == exp_err, "R9 err at req fall", int'(seen_err), int'(exp_err));
    if (exp_err)
      check(rdata == prev, "R9 rdata kept", int'(rdata), int'(prev));
    else
      check(rdata == exp_word(mode, w, m, v, junk), "R4 captured word", int'(rdata),
            int'(exp_word(mode, w, m, v, junk)));
    prev = rdata;
    @(negedge clk);
    check(!done && !err, "R7 single pulse", int'({done, err}), 0);
    check(req === 1'b0, "R8 idle gap", int'(req), 0);
    check(cmd_ready === 1'b1, "R8 ready again", int'(cmd_ready), 1);
    check(rdata == prev, "R11 rdata hold", int'(rdata), int'(prev));
    if (hold > 1) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(req === 1'b0, "R10 busy command ignored", int'(req), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check(!req && !done && !err && cmd_ready, "R1 in reset", int'({req, done, err, cmd_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req && !done && !err && cmd_ready, "R1 after reset", int'({req, done, err, cmd_ready}), 1);

    // directed corners
    xfer(0, 1, 0, 0, 0, 8'h3C);          // R3 data early
    xfer(0, A, 0, 0, 0, 8'hC3);          // R3 data on the last cycle
    xfer(1, 0, 1, 2, 0, 8'h11);          // R5 quick release
    xfer(1, 0, 1, 9, 0, 8'h22);          // R5 long handshake
    xfer(1, 0, A - 2, A + 3, 0, 8'h33);  // R4 wait seen exactly on the deadline edge
    xfer(1, 0, A - 1, A, 0, 8'h44);      // R4 wait one edge too late, data at deadline
    xfer(1, 0, A - 1, A + 2, 0, 8'h55);  // R4 too late, bus still junk
    xfer(2, 0, 1, 0, 0, 8'h66);          // R9 timeout
    xfer(0, 2, 0, 0, 3, 8'h77);          // R10 command held while busy
    xfer(1, 0, 1, 3, 0, 8'h88);          // recovery after timeout

    for (int i = 0; i < 60; i++) begin
      int r, w, m, d;
      logic [DW-1:0] v;
      r = $urandom_range(0, 9);
      v = DW'($urandom);
      d = $urandom_range(1, A);
      w = $urandom_range(1, A - 1);
      m = w + $urandom_range(1, 6);
      if (r < 5)      xfer(0, d, 0, 0, (r == 4) ? 2 : 0, v);
      else if (r < 9) xfer(1, 0, w, m, 0, v);
      else            xfer(2, 0, 1, 0, 0, v);
    end

    summary();
    $finish;
  end
endmodule